// File: doc/BRIEF.md
# Time Base Counter with Four Reference Compares

This block keeps a 64-bit time value that software reads as a steady time reference. The value steps up by one on every clock where the qualifying tick input is high, and it rolls over from all ones back to zero. Software can overwrite the lower or the upper 32-bit half of the counter on its own, for example to set the time after boot.

Four reference registers sit beside the counter. Each one is compared with the counter. When a tick moves the counter onto a reference value, the status bit for that reference becomes set. A status bit stays set until software writes a one to it. A mask register picks which status bits drive the single interrupt output. Processor register decoding and clock generation stay outside the block. The surrounding logic turns its bus accesses into the write strobes listed below.

Top module: `tick_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, all four reference registers, the status bits, the mask and `irq_o` all go to zero.
- R2: On a clock where `tick_en` is high and neither counter-half write strobe is high, `count_o` becomes its old value plus one. With `tick_en` low and no counter write, `count_o` holds its value.
- R3: A tick at value 0xFFFF_FFFF_FFFF_FFFF moves the counter to zero. A reference that holds zero fires on that tick.
- R4: `cnt_lo_we` loads `cnt_wdata` into `count_o[31:0]` and `cnt_hi_we` loads it into `count_o[63:32]`, both at the next clock. A half that is not written keeps its value. A clock with either strobe high does not count a tick.
- R5: `ref_we` writes `ref_wdata` into the reference selected by `ref_idx` (0 to 3, status bit n belongs to reference n). The compare on the same clock still uses the old reference value.
- R6: When a tick moves the counter to a value equal to reference n, `status_o[n]` is set on the same clock edge, so it shows in the same cycle as the new count. Every reference that matches sets its own bit, and references that do not match set none.
- R7: A match needs a tick. A held counter value does not fire again. Loading the counter onto a reference value does not fire. Writing a reference equal to the current count does not fire.
- R8: A status bit stays set until `clr_we` is high with a one in the bit's position of `clr_wdata`. The bit is then zero at the next clock. A zero in `clr_wdata` leaves its bit unchanged.
- R9: If a match sets a status bit on the same clock as a clear of that bit, the bit stays set.
- R10: `mask_we` loads `mask_wdata` into the mask at the next clock, and `mask_o` shows the mask.
- R11: `irq_o` is a register that is high exactly when some bit is set in both `status_o` and `mask_o`. It changes on the same clock edge as those two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the counter by one on this clock |
| cnt_lo_we | input | 1 | Load lower counter half from `cnt_wdata` |
| cnt_hi_we | input | 1 | Load upper counter half from `cnt_wdata` |
| cnt_wdata | input | 32 | Data for counter-half loads |
| ref_we | input | 1 | Write the selected reference register |
| ref_idx | input | 2 | Reference register select |
| ref_wdata | input | 64 | New reference value |
| mask_we | input | 1 | Load interrupt mask |
| mask_wdata | input | 4 | New mask, one enable per reference |
| clr_we | input | 1 | Write-one-to-clear strobe for status |
| clr_wdata | input | 4 | Status bits to clear |
| count_o | output | 64 | Current counter value |
| status_o | output | 4 | Sticky per-reference match flags |
| mask_o | output | 4 | Current interrupt mask |
| irq_o | output | 1 | Masked OR of the status flags |

## Verification
The bench first ticks the counter steadily across several references, including two that share one value. This shows that only the matching bits are set and that more than one bit can be set at once. It then holds the counter, loads it directly onto a reference value and writes a reference equal to the live count. These patterns tell a real tick-driven match apart from a plain equality test. Directed cases cover the rollover from all ones, a clear on the same clock as a match, and a counter write on the same clock as a tick. A long randomized run then mixes ticks, reference writes placed just ahead of the count, clears and mask changes, and it compares every output against a behavioural model on every cycle.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  // what the counter does on a given clock
  typedef enum logic [1:0] {
    CNT_IDLE = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/tick_timebase_counter.sv
module tick_timebase_counter
  import tick_timebase_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter bit SPLIT_INC = 1'b1,
  localparam int HALF_W   = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic              step_o
);
  cnt_op_e          op;
  logic [CNT_W-1:0] inc;

  // a load always wins over a tick on the same clock
  always_comb begin
    if (lo_we || hi_we)  op = CNT_LOAD;
    else if (tick_en)    op = CNT_STEP;
    else                 op = CNT_IDLE;
  end

  generate
    if (SPLIT_INC) begin : g_split
      // lower half adds first, its carry ripples into the upper half
      logic [HALF_W:0] lo_sum;
      assign lo_sum = {1'b0, cnt_q[HALF_W-1:0]} + {{HALF_W{1'b0}}, 1'b1};
      assign inc = {cnt_q[CNT_W-1:HALF_W] + {{(CNT_W-HALF_W-1){1'b0}}, lo_sum[HALF_W]},
                    lo_sum[HALF_W-1:0]};
    end else begin : g_flat
      assign inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  endgenerate

  always_comb begin
    cnt_nxt = cnt_q;
    unique case (op)
      CNT_STEP: cnt_nxt = inc;
      CNT_LOAD: begin
        if (lo_we) cnt_nxt[HALF_W-1:0]     = wdata;
        if (hi_we) cnt_nxt[CNT_W-1:HALF_W] = wdata;
      end
      default:  cnt_nxt = cnt_q;
    endcase
  end

  assign step_o = (op == CNT_STEP);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tick_timebase_refs.sv
module tick_timebase_refs #(
  parameter int CNT_W = 64,
  parameter int NREF  = 4,
  localparam int IDX_W = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             step,
  output logic [NREF-1:0]  hit_o
);
  generate
    for (genvar g = 0; g < NREF; g++) begin : g_ref
      logic [CNT_W-1:0] ref_q;

      always_ff @(posedge clk) begin
        if (rst)                           ref_q <= '0;
        else if (we && idx == IDX_W'(g))   ref_q <= wdata;
      end

      // compared against the value the counter is about to take
      assign hit_o[g] = step && (cnt_nxt == ref_q);
    end
  endgenerate
endmodule

// File: rtl/tick_timebase_flags.sv
module tick_timebase_flags #(
  parameter int NREF = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREF-1:0] hit,
  input  logic            clr_we,
  input  logic [NREF-1:0] clr_wdata,
  input  logic            mask_we,
  input  logic [NREF-1:0] mask_wdata,
  output logic [NREF-1:0] status_o,
  output logic [NREF-1:0] mask_o,
  output logic            irq_o
);
  logic [NREF-1:0] clr_vec;
  logic [NREF-1:0] stat_nxt;
  logic [NREF-1:0] mask_nxt;

  assign clr_vec  = clr_we ? clr_wdata : '0;
  // a fresh hit overrides a clear of the same bit
  assign stat_nxt = (status_o & ~clr_vec) | hit;
  assign mask_nxt = mask_we ? mask_wdata : mask_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      mask_o   <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= stat_nxt;
      mask_o   <= mask_nxt;
      irq_o    <= |(stat_nxt & mask_nxt);
    end
  end
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int CNT_W     = 64,
  parameter int NREF      = 4,
  parameter bit SPLIT_INC = 1'b1,
  localparam int HALF_W   = CNT_W / 2,
  localparam int IDX_W    = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cnt_lo_we,
  input  logic              cnt_hi_we,
  input  logic [HALF_W-1:0] cnt_wdata,
  input  logic              ref_we,
  input  logic [IDX_W-1:0]  ref_idx,
  input  logic [CNT_W-1:0]  ref_wdata,
  input  logic              mask_we,
  input  logic [NREF-1:0]   mask_wdata,
  input  logic              clr_we,
  input  logic [NREF-1:0]   clr_wdata,
  output logic [CNT_W-1:0]  count_o,
  output logic [NREF-1:0]   status_o,
  output logic [NREF-1:0]   mask_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;
  logic [NREF-1:0]  hit;

  tick_timebase_counter #(.CNT_W(CNT_W), .SPLIT_INC(SPLIT_INC)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .lo_we   (cnt_lo_we),
    .hi_we   (cnt_hi_we),
    .wdata   (cnt_wdata),
    .cnt_q   (count_o),
    .cnt_nxt (cnt_nxt),
    .step_o  (step)
  );

  tick_timebase_refs #(.CNT_W(CNT_W), .NREF(NREF)) u_refs (
    .clk     (clk),
    .rst     (rst),
    .we      (ref_we),
    .idx     (ref_idx),
    .wdata   (ref_wdata),
    .cnt_nxt (cnt_nxt),
    .step    (step),
    .hit_o   (hit)
  );

  tick_timebase_flags #(.NREF(NREF)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .clr_we     (clr_we),
    .clr_wdata  (clr_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .status_o   (status_o),
    .mask_o     (mask_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/tick_timebase_chk.sv
module tick_timebase_chk #(
  parameter int CNT_W = 64,
  parameter int NREF  = 4,
  localparam int HALF_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              cnt_lo_we,
  input logic              cnt_hi_we,
  input logic [HALF_W-1:0] cnt_wdata,
  input logic              clr_we,
  input logic [NREF-1:0]   clr_wdata,
  input logic [CNT_W-1:0]  count_o,
  input logic [NREF-1:0]   status_o,
  input logic [NREF-1:0]   mask_o,
  input logic              irq_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && status_o == '0 && mask_o == '0 && !irq_o));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_lo_we && !cnt_hi_we) |=> $stable(count_o));

  // R2 (also covers the wrap of R3)
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_lo_we && !cnt_hi_we) |=> (count_o == $past(count_o) + 1'b1));

  // R4
  lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_lo_we |=> (count_o[HALF_W-1:0] == $past(cnt_wdata)));

  // R4
  hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_lo_we && !cnt_hi_we) |=> (count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W])));

  // R7
  no_tick_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en || cnt_lo_we || cnt_hi_we) |=> ((status_o & ~$past(status_o)) == '0));

  // R8
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !tick_en) |=> ((status_o & $past(clr_wdata)) == '0));

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_o & mask_o));
endmodule

bind tick_timebase tick_timebase_chk #(.CNT_W(CNT_W), .NREF(NREF)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .cnt_lo_we (cnt_lo_we),
  .cnt_hi_we (cnt_hi_we),
  .cnt_wdata (cnt_wdata),
  .clr_we    (clr_we),
  .clr_wdata (clr_wdata),
  .count_o   (count_o),
  .status_o  (status_o),
  .mask_o    (mask_o),
  .irq_o     (irq_o)
);

// File: tb/tick_timebase_bench.sv
`timescale 1ns/1ps
module tick_timebase_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        cnt_lo_we = 1'b0;
  logic        cnt_hi_we = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic        ref_we = 1'b0;
  logic [1:0]  ref_idx = '0;
  logic [63:0] ref_wdata = '0;
  logic        mask_we = 1'b0;
  logic [3:0]  mask_wdata = '0;
  logic        clr_we = 1'b0;
  logic [3:0]  clr_wdata = '0;
  logic [63:0] count_o;
  logic [3:0]  status_o;
  logic [3:0]  mask_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  tick_timebase u_tick_timebase (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_wdata(cnt_wdata),
    .ref_we(ref_we), .ref_idx(ref_idx), .ref_wdata(ref_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .count_o(count_o), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  // behavioural model
  logic [63:0] m_cnt;
  logic [63:0] m_ref [4];
  logic [3:0]  m_stat;
  logic [3:0]  m_mask;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clock();
    logic [3:0]  hit;
    logic [63:0] n;
    hit = '0;
    if (rst) begin
      m_cnt = '0; m_stat = '0; m_mask = '0;
      for (int i = 0; i < 4; i++) m_ref[i] = '0;
    end else begin
      if (!cnt_lo_we && !cnt_hi_we && tick_en) begin
        n = m_cnt + 64'd1;
        for (int i = 0; i < 4; i++) hit[i] = (n == m_ref[i]);
        m_cnt = n;
      end else begin
        if (cnt_lo_we) m_cnt[31:0]  = cnt_wdata;
        if (cnt_hi_we) m_cnt[63:32] = cnt_wdata;
      end
      if (ref_we) m_ref[ref_idx] = ref_wdata;
      if (clr_we) m_stat = m_stat & ~clr_wdata;
      m_stat = m_stat | hit;
      if (mask_we) m_mask = mask_wdata;
    end
  endtask

  // one clock with the currently driven inputs, then compare and release strobes
  task automatic step();
    @(posedge clk);
    model_clock();
    @(negedge clk);
    chk({phase, " count"},  count_o,        m_cnt);
    chk({phase, " status"}, 64'(status_o),  64'(m_stat));
    chk({phase, " mask"},   64'(mask_o),    64'(m_mask));
    chk({phase, " irq"},    64'(irq_o),     64'(|(m_stat & m_mask)));
    tick_en = 1'b0; cnt_lo_we = 1'b0; cnt_hi_we = 1'b0;
    ref_we = 1'b0; mask_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick_en = 1'b1; step(); end
  endtask

  task automatic load_cnt(logic [63:0] v);
    cnt_lo_we = 1'b1; cnt_wdata = v[31:0]; step();
    cnt_hi_we = 1'b1; cnt_wdata = v[63:32]; step();
  endtask

  task automatic set_ref(int i, logic [63:0] v);
    ref_we = 1'b1; ref_idx = 2'(i); ref_wdata = v; step();
  endtask

  initial begin
    phase = "R1";
    step(); step();
    chk("R1 count zero", count_o, 64'd0);
    chk("R1 irq low", 64'(irq_o), 64'd0);
    rst = 1'b0;
    step();

    phase = "R2";
    ticks(3);
    step(); step();
    chk("R2 count after three ticks", count_o, 64'd3);

    phase = "R10";
    mask_we = 1'b1; mask_wdata = 4'b0101; step();

    phase = "R5";
    set_ref(0, 64'd8);
    set_ref(1, 64'd10);
    set_ref(2, 64'd10);

    phase = "R6";
    ticks(5);
    chk("R6 ref0 fired", 64'(status_o), 64'b0001);
    ticks(2);
    chk("R6 ref1 and ref2 fired together", 64'(status_o), 64'b0111);
    chk("R11 irq from masked bits", 64'(irq_o), 64'd1);

    phase = "R7";
    step(); step(); step();
    clr_we = 1'b1; clr_wdata = 4'b0111; step();
    chk("R8 all cleared", 64'(status_o), 64'd0);
    load_cnt(64'd8);
    chk("R7 load onto ref does not fire", 64'(status_o), 64'd0);
    set_ref(3, 64'd8);
    step();
    chk("R7 ref equal to count does not fire", 64'(status_o), 64'd0);

    phase = "R8";
    load_cnt(64'd7);
    ticks(1);
    chk("R8 ref0 and ref3 set", 64'(status_o), 64'b1001);
    clr_we = 1'b1; clr_wdata = 4'b0000; step();
    chk("R8 zero clear ignored", 64'(status_o), 64'b1001);
    clr_we = 1'b1; clr_wdata = 4'b1000; step();
    chk("R8 one bit cleared", 64'(status_o), 64'b0001);

    phase = "R9";
    load_cnt(64'd7);
    tick_en = 1'b1; clr_we = 1'b1; clr_wdata = 4'b0001; step();
    chk("R9 match beats clear", 64'(status_o), 64'b1001);
    clr_we = 1'b1; clr_wdata = 4'b1111; step();

    phase = "R4";
    tick_en = 1'b1; cnt_lo_we = 1'b1; cnt_wdata = 32'h1234_5678; step();
    chk("R4 write suppresses tick", count_o, 64'h0000_0000_1234_5678);
    cnt_hi_we = 1'b1; cnt_wdata = 32'hCAFE_0001; step();
    chk("R4 upper half only", count_o, 64'hCAFE_0001_1234_5678);
    cnt_hi_we = 1'b1; cnt_lo_we = 1'b1; cnt_wdata = 32'h0000_00AA; step();
    chk("R4 both halves", count_o, 64'h0000_00AA_0000_00AA);

    phase = "R3";
    set_ref(3, 64'd0);
    mask_we = 1'b1; mask_wdata = 4'b1000; step();
    load_cnt(64'hFFFF_FFFF_FFFF_FFFE);
    ticks(1);
    chk("R3 no fire before wrap", 64'(status_o), 64'd0);
    ticks(1);
    chk("R3 wrapped to zero", count_o, 64'd0);
    chk("R3 zero ref fired on wrap", 64'(status_o), 64'b1000);
    chk("R11 irq on wrap match", 64'(irq_o), 64'd1);

    phase = "R6 random";
    for (int i = 0; i < 600; i++) begin
      tick_en = ($urandom % 4) != 0;
      if (($urandom % 5) == 0) begin
        ref_we = 1'b1; ref_idx = 2'($urandom % 4);
        ref_wdata = m_cnt + 64'($urandom % 6);
      end
      if (($urandom % 7) == 0) begin clr_we = 1'b1; clr_wdata = 4'($urandom); end
      if (($urandom % 11) == 0) begin mask_we = 1'b1; mask_wdata = 4'($urandom); end
      if (($urandom % 29) == 0) begin
        cnt_lo_we = 1'b1; cnt_wdata = m_cnt[31:0] - 32'($urandom % 4);
      end
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule